// File: doc/BRIEF.md
# Pseudo-Random Sequence Checker with Lock Monitor

This block receives test bits pulled out of a payload stream, one bit per cycle on which a valid strobe is high, and checks them against a pseudo-random sequence that it rebuilds locally. A two-bit selector picks one of three maximal-length sequences. While it is hunting, the checker loads its local register from the incoming bits. Once a run of predictions has matched, it declares lock and lets the register run freely. From then on every mismatching received bit counts as a bit error.

Lock is dropped when too many errors fall into one 48-bit block of the stream. Each bit error produces a one-cycle pulse for an external performance counter and sets a sticky error flag. Each change of the lock state, gain or loss, sets a sticky change flag. The two sticky flags feed one interrupt line through separate enable bits. A received-bit inversion control lets the block check a complemented stream.

Top module: `prbs_sync_monitor`

## Requirements
- R1: While and after reset, syncOk, syncChgFlag, bitErrFlag, bitErrPulse and irq are all 0.
- R2: Each received bit x[n] is predicted from the earlier received bits. patSel=0 predicts x[n-9] xor x[n-11] (length 11). patSel=1 predicts x[n-14] xor x[n-15] (length 15). patSel=2 or 3 predicts x[n-3] xor x[n-20] (length 20). After a hunt starts, the first L valid bits only fill the register, where L is the length. Lock is declared on the clock edge that takes the 32nd consecutive correct prediction after that fill, which is valid bit L+32 of an error-free stream.
- R3: A 0-to-1 change of testEn starts a new hunt. The bit offered in that same cycle is discarded. While testEn is 0, syncOk is 0 from the next edge onward and no events occur.
- R4: With rxInv=1 each received bit is complemented before it is compared, so a complemented stream locks. With rxInv=0 a complemented stream never locks.
- R5: While locked, each valid bit that differs from the local sequence gives bitErrPulse high for exactly the one cycle after its edge and sets bitErrFlag. A received error does not disturb the local sequence.
- R6: Once locked, valid bits are grouped into back-to-back 48-bit blocks, starting at the first bit after lock. The 11th error inside one block drops lock on that bit's edge. Ten errors in a block keep lock, and the count starts again at each new block.
- R7: Every change of syncOk, whether rising or falling, sets syncChgFlag on the same edge.
- R8: irq is high exactly when (bitErrFlag and errIrqEn) or (syncChgFlag and syncIrqEn).
- R9: A clrErrFlag or clrSyncFlag pulse clears its flag. A new event on the same edge wins over the clear, and the flag stays 1.
- R10: Cycles with bitValid=0 change no state and produce no events.
- R11: No bit-error events are produced while hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| testEn | input | 1 | Test enable; a rising edge starts a hunt |
| patSel | input | 2 | Sequence select (0: length 11, 1: length 15, 2/3: length 20) |
| rxInv | input | 1 | Complement received bits before checking |
| bitValid | input | 1 | rxBit carries a test bit this cycle |
| rxBit | input | 1 | Extracted test bit |
| errIrqEn | input | 1 | Interrupt enable for the error flag |
| syncIrqEn | input | 1 | Interrupt enable for the lock-change flag |
| clrErrFlag | input | 1 | Write-one-to-clear pulse for bitErrFlag |
| clrSyncFlag | input | 1 | Write-one-to-clear pulse for syncChgFlag |
| syncOk | output | 1 | Lock status |
| syncChgFlag | output | 1 | Sticky lock-change flag |
| bitErrFlag | output | 1 | Sticky bit-error flag |
| bitErrPulse | output | 1 | One-cycle pulse per bit error |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions check several properties on every cycle. A change of lock always comes with the change flag. An error pulse follows only a locked cycle and always comes with the sticky flag. The per-block error count never exceeds ten. Lock rises only after a full run of matches, and a low enable means no lock. Only the bench scenarios can show the exact bit on which lock is gained for each sequence, the alignment of the 48-bit blocks, and the split of twenty errors across a block boundary that keeps lock. The same holds for the complemented-stream cases, for clear-versus-event ordering, and for the discarded bit on the enable edge.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;
  localparam int REG_W  = 20;
  localparam int FILL_W = $clog2(REG_W + 1);

  typedef struct packed {
    logic clearReg;
    logic shift;
    logic useLocal;
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_SYNC = 2'd2
  } monState_e;

  function automatic logic [FILL_W-1:0] patLen(input logic [1:0] sel);
    case (sel)
      2'd0:    patLen = FILL_W'(11);
      2'd1:    patLen = FILL_W'(15);
      default: patLen = FILL_W'(20);
    endcase
  endfunction
endpackage

// File: rtl/prbs_mon_dp.sv
module prbs_mon_dp
  import prbs_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic [1:0] patSel,
  input  logic       rxInv,
  input  logic       rxBit,
  output logic       bitMiss
);
  logic [REG_W-1:0] shiftReg;
  logic inBit;
  logic predBit;

  assign inBit = rxBit ^ rxInv;

  always_comb begin
    case (patSel)
      2'd0:    predBit = shiftReg[8]  ^ shiftReg[10];
      2'd1:    predBit = shiftReg[13] ^ shiftReg[14];
      default: predBit = shiftReg[2]  ^ shiftReg[19];
    endcase
  end

  assign bitMiss = inBit ^ predBit;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearReg) begin
      shiftReg <= '0;
    end else if (ctl.shift) begin
      shiftReg <= {shiftReg[REG_W-2:0], ctl.useLocal ? predBit : inBit};
    end
  end
endmodule

// File: rtl/prbs_mon_ctrl.sv
module prbs_mon_ctrl
  import prbs_mon_pkg::*;
#(
  parameter int SYNC_MATCH = 32,
  parameter int WIN_LEN    = 48,
  parameter int ERR_LIMIT  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       testEn,
  input  logic [1:0] patSel,
  input  logic       bitValid,
  input  logic       bitMiss,
  input  logic       errIrqEn,
  input  logic       syncIrqEn,
  input  logic       clrErrFlag,
  input  logic       clrSyncFlag,
  output dpCtl_t     ctl,
  output logic       syncOk,
  output logic       syncChgFlag,
  output logic       bitErrFlag,
  output logic       bitErrPulse,
  output logic       irq
);
  localparam int MATCH_W = $clog2(SYNC_MATCH);
  localparam int BLK_W   = $clog2(WIN_LEN);
  localparam int ERR_W   = $clog2(ERR_LIMIT + 1);

  monState_e state, stateNxt;
  logic [FILL_W-1:0]  fillCnt, fillNxt;
  logic [MATCH_W-1:0] matchCnt, matchNxt;
  logic [BLK_W-1:0]   blkCnt, blkNxt;
  logic [ERR_W-1:0]   errCnt, errNxt;
  logic testEnQ;
  logic startPulse;
  logic errEvt;
  logic syncChange;

  assign startPulse = testEn & ~testEnQ;

  always_comb begin
    stateNxt = state;
    fillNxt  = fillCnt;
    matchNxt = matchCnt;
    blkNxt   = blkCnt;
    errNxt   = errCnt;
    ctl      = '0;
    errEvt   = 1'b0;
    if (!testEn) begin
      stateNxt = ST_IDLE;
    end else if (startPulse) begin
      stateNxt     = ST_HUNT;
      fillNxt      = '0;
      matchNxt     = '0;
      ctl.clearReg = 1'b1;
    end else if (bitValid) begin
      case (state)
        ST_HUNT: begin
          ctl.shift = 1'b1;
          if (fillCnt < patLen(patSel)) begin
            fillNxt  = fillCnt + 1'b1;
            matchNxt = '0;
          end else if (bitMiss) begin
            matchNxt = '0;
          end else if (matchCnt == MATCH_W'(SYNC_MATCH - 1)) begin
            stateNxt = ST_SYNC;
            blkNxt   = '0;
            errNxt   = '0;
          end else begin
            matchNxt = matchCnt + 1'b1;
          end
        end
        ST_SYNC: begin
          ctl.shift    = 1'b1;
          ctl.useLocal = 1'b1;
          errEvt       = bitMiss;
          if (bitMiss && errCnt == ERR_W'(ERR_LIMIT)) begin
            stateNxt = ST_HUNT;
            fillNxt  = '0;
            matchNxt = '0;
          end else if (blkCnt == BLK_W'(WIN_LEN - 1)) begin
            blkNxt = '0;
            errNxt = '0;
          end else begin
            blkNxt = blkCnt + 1'b1;
            errNxt = errCnt + ERR_W'(bitMiss);
          end
        end
        default: ;
      endcase
    end
  end

  assign syncChange = (stateNxt == ST_SYNC) != (state == ST_SYNC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      fillCnt     <= '0;
      matchCnt    <= '0;
      blkCnt      <= '0;
      errCnt      <= '0;
      testEnQ     <= 1'b0;
      syncChgFlag <= 1'b0;
      bitErrFlag  <= 1'b0;
      bitErrPulse <= 1'b0;
    end else begin
      state       <= stateNxt;
      fillCnt     <= fillNxt;
      matchCnt    <= matchNxt;
      blkCnt      <= blkNxt;
      errCnt      <= errNxt;
      testEnQ     <= testEn;
      syncChgFlag <= syncChange | (syncChgFlag & ~clrSyncFlag);
      bitErrFlag  <= errEvt | (bitErrFlag & ~clrErrFlag);
      bitErrPulse <= errEvt;
    end
  end

  assign syncOk = (state == ST_SYNC);
  assign irq    = (bitErrFlag & errIrqEn) | (syncChgFlag & syncIrqEn);

  assert_change_sets_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (syncOk != $past(syncOk)) |-> syncChgFlag);
  assert_pulse_only_after_sync_R11: assert property (@(posedge clk) disable iff (!rstN)
    bitErrPulse |-> ($past(state) == ST_SYNC));
  assert_pulse_sets_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitErrPulse |-> bitErrFlag);
  assert_block_count_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= ERR_W'(ERR_LIMIT));
  assert_lock_after_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOk) |-> ($past(matchCnt) == MATCH_W'(SYNC_MATCH - 1)));
  assert_disabled_unlocked_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(!testEn) |-> !syncOk);
endmodule

// File: rtl/prbs_sync_monitor.sv
module prbs_sync_monitor
  import prbs_mon_pkg::*;
#(
  parameter int SYNC_MATCH = 32,
  parameter int WIN_LEN    = 48,
  parameter int ERR_LIMIT  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       testEn,
  input  logic [1:0] patSel,
  input  logic       rxInv,
  input  logic       bitValid,
  input  logic       rxBit,
  input  logic       errIrqEn,
  input  logic       syncIrqEn,
  input  logic       clrErrFlag,
  input  logic       clrSyncFlag,
  output logic       syncOk,
  output logic       syncChgFlag,
  output logic       bitErrFlag,
  output logic       bitErrPulse,
  output logic       irq
);
  dpCtl_t dpCtl;
  logic   bitMiss;

  prbs_mon_dp i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (dpCtl),
    .patSel (patSel),
    .rxInv  (rxInv),
    .rxBit  (rxBit),
    .bitMiss(bitMiss)
  );

  prbs_mon_ctrl #(
    .SYNC_MATCH(SYNC_MATCH),
    .WIN_LEN   (WIN_LEN),
    .ERR_LIMIT (ERR_LIMIT)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .testEn     (testEn),
    .patSel     (patSel),
    .bitValid   (bitValid),
    .bitMiss    (bitMiss),
    .errIrqEn   (errIrqEn),
    .syncIrqEn  (syncIrqEn),
    .clrErrFlag (clrErrFlag),
    .clrSyncFlag(clrSyncFlag),
    .ctl        (dpCtl),
    .syncOk     (syncOk),
    .syncChgFlag(syncChgFlag),
    .bitErrFlag (bitErrFlag),
    .bitErrPulse(bitErrPulse),
    .irq        (irq)
  );
endmodule

// File: tb/test_prbs_sync_monitor.sv
`timescale 1ns/1ps
module test_prbs_sync_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testEn = 1'b0, rxInv = 1'b0, bitValid = 1'b0, rxBit = 1'b0;
  logic [1:0] patSel = 2'd0;
  logic errIrqEn = 1'b0, syncIrqEn = 1'b0, clrErrFlag = 1'b0, clrSyncFlag = 1'b0;
  logic syncOk, syncChgFlag, bitErrFlag, bitErrPulse, irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [19:0] hist;
  logic invStream = 1'b0;
  logic gapsOn = 1'b1;

  always #4 clk = ~clk;

  prbs_sync_monitor i_prbs_sync_monitor (
    .clk(clk), .rstN(rstN), .testEn(testEn), .patSel(patSel), .rxInv(rxInv),
    .bitValid(bitValid), .rxBit(rxBit), .errIrqEn(errIrqEn), .syncIrqEn(syncIrqEn),
    .clrErrFlag(clrErrFlag), .clrSyncFlag(clrSyncFlag), .syncOk(syncOk),
    .syncChgFlag(syncChgFlag), .bitErrFlag(bitErrFlag), .bitErrPulse(bitErrPulse), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: run did not finish (actual cycles=%0d expected<150000)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  function automatic int seqLen(input logic [1:0] sel);
    return (sel == 2'd0) ? 11 : (sel == 2'd1) ? 15 : 20;
  endfunction

  function automatic logic nextSeqBit(input logic [19:0] h, input logic [1:0] sel);
    case (sel)
      2'd0:    return h[8] ^ h[10];
      2'd1:    return h[13] ^ h[14];
      default: return h[2] ^ h[19];
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic stepIn(input logic v, input logic b, input logic ce, input logic cs);
    @(negedge clk);
    bitValid = v; rxBit = b; clrErrFlag = ce; clrSyncFlag = cs;
    @(posedge clk);
    #2;
    bitValid = 1'b0; clrErrFlag = 1'b0; clrSyncFlag = 1'b0;
  endtask

  task automatic seqBit(input logic flip, input logic ce);
    logic b;
    if (gapsOn) begin
      int g = $urandom % 3;
      for (int i = 0; i < g; i++) stepIn(1'b0, 1'($urandom), 1'b0, 1'b0);
    end
    b = nextSeqBit(hist, patSel);
    hist = {hist[18:0], b};
    stepIn(1'b1, b ^ invStream ^ flip, ce, 1'b0);
  endtask

  task automatic startTest(input logic [1:0] sel, input logic inv, input logic invS);
    @(negedge clk);
    testEn = 1'b0; patSel = sel; rxInv = inv; invStream = invS;
    @(posedge clk); #2;
    @(negedge clk);
    testEn = 1'b1; bitValid = 1'b1; rxBit = 1'($urandom);   // R3 offered bit must be discarded
    @(posedge clk); #2;
    bitValid = 1'b0;
    hist = 20'($urandom) | 20'h1;
  endtask

  task automatic acquire(input string req);
    int len = seqLen(patSel);
    for (int i = 0; i < len + 31; i++) seqBit(1'b0, 1'b0);
    chk(req, "syncOk one bit before lock", int'(syncOk), 0);
    seqBit(1'b0, 1'b0);
    chk(req, "syncOk at lock bit", int'(syncOk), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "syncOk in reset", int'(syncOk), 0);
    chk("R1", "syncChgFlag in reset", int'(syncChgFlag), 0);
    chk("R1", "bitErrFlag in reset", int'(bitErrFlag), 0);
    chk("R1", "bitErrPulse in reset", int'(bitErrPulse), 0);
    errIrqEn = 1'b1; syncIrqEn = 1'b1; #1;
    chk("R1", "irq in reset", int'(irq), 0);
    errIrqEn = 1'b0; syncIrqEn = 1'b0;
    @(negedge clk); rstN = 1'b1;

    // R11 hunting on random data never raises an error event
    startTest(2'd0, 1'b0, 1'b0);
    begin
      int seen = 0;
      for (int i = 0; i < 120; i++) begin
        stepIn(1'b1, 1'($urandom), 1'b0, 1'b0);
        if (bitErrPulse) seen++;
      end
      chk("R11", "error pulses while hunting", seen, 0);
      chk("R11", "bitErrFlag after hunting", int'(bitErrFlag), 0);
    end

    // R2 lock timing for every sequence, with idle gaps (R10)
    for (int s = 0; s < 4; s++) begin
      startTest(2'(s), 1'b0, 1'b0);
      stepIn(1'b0, 1'b0, 1'b0, 1'b1);
      acquire("R2");
      chk("R7", "change flag on lock", int'(syncChgFlag), 1);
    end

    // R10 invalid cycles with wrong data are ignored while locked
    stepIn(1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) begin
      stepIn(1'b0, ~nextSeqBit(hist, patSel), 1'b0, 1'b0);
      chk("R10", "no pulse on invalid cycle", int'(bitErrPulse), 0);
    end
    chk("R10", "still locked after invalid cycles", int'(syncOk), 1);
    chk("R10", "bitErrFlag unchanged", int'(bitErrFlag), 0);

    // R5 single error
    seqBit(1'b1, 1'b0);
    chk("R5", "pulse after error bit", int'(bitErrPulse), 1);
    chk("R5", "bitErrFlag after error", int'(bitErrFlag), 1);
    seqBit(1'b0, 1'b0);
    chk("R5", "pulse lasts one cycle", int'(bitErrPulse), 0);
    chk("R5", "lock kept after single error", int'(syncOk), 1);

    // R6 block window: fresh lock for known alignment
    startTest(2'd1, 1'b0, 1'b0);
    acquire("R2");
    stepIn(1'b0, 1'b0, 1'b1, 1'b1);
    for (int p = 0; p < 48; p++) seqBit(p < 10, 1'b0);
    chk("R6", "ten errors in block keep lock", int'(syncOk), 1);
    for (int p = 0; p < 48; p++) seqBit(p >= 38, 1'b0);
    chk("R6", "ten late errors keep lock", int'(syncOk), 1);
    for (int p = 0; p < 10; p++) seqBit(1'b1, 1'b0);
    chk("R6", "count restarts at new block", int'(syncOk), 1);
    chk("R7", "no change flag while locked", int'(syncChgFlag), 0);
    seqBit(1'b1, 1'b0);
    chk("R6", "eleventh error drops lock", int'(syncOk), 0);
    chk("R5", "pulse on dropping error", int'(bitErrPulse), 1);
    chk("R7", "change flag on loss", int'(syncChgFlag), 1);

    // R8 interrupt masking
    @(negedge clk);
    errIrqEn = 1'b0; syncIrqEn = 1'b0; #1;
    chk("R8", "irq both masked", int'(irq), 0);
    errIrqEn = 1'b1; #1;
    chk("R8", "irq from error flag", int'(irq), 1);
    stepIn(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9", "error flag cleared", int'(bitErrFlag), 0);
    chk("R8", "irq with error flag clear", int'(irq), 0);
    syncIrqEn = 1'b1; #1;
    chk("R8", "irq from change flag", int'(irq), 1);
    stepIn(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R9", "change flag cleared", int'(syncChgFlag), 0);
    chk("R8", "irq after both cleared", int'(irq), 0);
    errIrqEn = 1'b0; syncIrqEn = 1'b0;

    // R9 event beats clear on the same edge
    startTest(2'd2, 1'b0, 1'b0);
    acquire("R2");
    stepIn(1'b0, 1'b0, 1'b1, 1'b1);
    seqBit(1'b1, 1'b1);
    chk("R9", "error flag set despite clear", int'(bitErrFlag), 1);

    // R4 complemented stream with inversion on, then R3 disable
    startTest(2'd1, 1'b1, 1'b1);
    acquire("R4");
    stepIn(1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk); testEn = 1'b0;
    @(posedge clk); #2;
    chk("R3", "disable drops lock", int'(syncOk), 0);
    chk("R7", "change flag on disable", int'(syncChgFlag), 1);
    stepIn(1'b0, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 60; i++) seqBit(1'b1, 1'b0);
    chk("R3", "no events while disabled", int'(bitErrFlag) + int'(syncOk) + int'(syncChgFlag), 0);

    // R4 complemented stream without inversion never locks
    startTest(2'd1, 1'b0, 1'b1);
    for (int i = 0; i < 200; i++) seqBit(1'b0, 1'b0);
    chk("R4", "complemented stream without inversion", int'(syncOk), 0);

    // Random error injection against a block-window model
    begin
      int blkPos = 0, errs = 0, mism = 0;
      logic expSync = 1'b1;
      startTest(2'd2, 1'b0, 1'b0);
      acquire("R2");
      for (int i = 0; i < 600 && expSync; i++) begin
        logic f = ($urandom % 9) == 0;
        seqBit(f, 1'b0);
        if (bitErrPulse != f) mism++;
        if (f && errs == 10) expSync = 1'b0;
        else if (blkPos == 47) begin blkPos = 0; errs = 0; end
        else begin blkPos++; errs += int'(f); end
        if (syncOk != expSync) mism++;
      end
      chk("R6", "random errors vs window model", mism, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule